// File: doc/BRIEF.md
# Sized Add-With-Carry Flag ALU

This unit forms the sum of a destination operand, a source operand and an incoming carry bit. The operand size is selectable at 8, 16, 32 or 64 bits. It returns the sum cut to that size, with every bit above the size forced to zero. It also returns six arithmetic status flags: carry, signed overflow, sign, zero, auxiliary (nibble) carry and parity.

When the source is an immediate, the unit first sign-extends it from its own width, then adds it. A multiword addition is built from a sequence of operations, where each carry flag output becomes the next carry input. For the first step, the carry input is tied low.

Outputs are registered. A request presented with `in_valid` appears on the outputs one clock later, together with `out_valid`. The outputs keep their values until the next request arrives.

Top module: `adc_flag_alu`

## Requirements
- R1: `result` equals `dst + src_eff + carry_in` reduced modulo 2^W, where W is 8, 16, 32 or 64 for `op_size` codes 0, 1, 2 and 3. Bits at position W and above are zero.
- R2: With `src_is_imm` high, the low 8, 16 or 32 bits of `src` (for `imm_width` codes 0, 1 and 2) are sign-extended before the add. Code 3 uses all 64 bits unchanged. With `src_is_imm` low, `src` is used without extension. Only the low W bits of both operands take part.
- R3: `cf` is the unsigned carry out of bit W-1.
- R4: `of` is high when both addends have equal bit W-1 and the result's bit W-1 differs from it. The carry input is included in the result used for this test.
- R5: `sf` equals bit W-1 of `result`.
- R6: `zf` is high exactly when the W-bit result is zero.
- R7: `af` equals bit 4 of (dst XOR src_eff XOR result).
- R8: `pf` is high when `result[7:0]` holds an even number of ones, at every size.
- R9: A request with `in_valid` high at a rising edge updates the outputs at that edge and raises `out_valid`. With `in_valid` low, `out_valid` drops at the next edge and `result` and the flags hold their values.
- R10: While `rst_n` is low, `out_valid`, `result` and all flags are zero.
- R11: An add with carry input 0, followed by add-with-carry steps that each take the previous `cf`, yields the correct multiword sum and final carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| dst | input | 64 | Destination operand |
| src | input | 64 | Source operand or immediate |
| op_size | input | 2 | Operand size code: 0=8, 1=16, 2=32, 3=64 bits |
| carry_in | input | 1 | Incoming carry |
| src_is_imm | input | 1 | Source is an immediate |
| imm_width | input | 2 | Immediate width code: 0=8, 1=16, 2=32, 3=64 bits |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 64 | Size-truncated sum, upper bits zero |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| af | output | 1 | Auxiliary carry flag |
| pf | output | 1 | Parity flag |

## Verification
The bench uses dirty upper bits in the destination at 16 bits. A unit that failed to mask would give a nonzero result and a clear zero flag. A 64-bit add of an all-ones destination with carry input 1 must wrap to zero with `cf` set; carry taken at a fixed bit position would miss it.

Negative 8-bit and 32-bit immediates are added at wider sizes. Treating them as zero-extended would give no carry and the wrong sign. An unextended register source with its top bit set in the low word must not be sign-extended. A wrong immediate width or a wrong choice between immediate and register would show as a wrong result.

Signed overflow produced only by the carry input (0x7F + 0 + 1) catches an overflow test that leaves the carry out. Chained 8-bit and 64-bit multiword sums catch a carry flag that is not fed through correctly.

// File: rtl/adc_pkg.sv
package adc_pkg;
    localparam int XLEN    = 64;
    localparam int SZ_W    = 2;
    localparam int N_SIZES = 4;

    typedef enum logic [SZ_W-1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } opsize_e;

    typedef struct packed {
        logic of_f;
        logic sf_f;
        logic zf_f;
        logic af_f;
        logic pf_f;
        logic cf_f;
    } flags_t;

    function automatic logic [XLEN-1:0] size_mask(input logic [SZ_W-1:0] sz);
        logic [XLEN-1:0] m;
        m = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (i < (8 << sz)) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/adc_imm_extend.sv
module adc_imm_extend
    import adc_pkg::*;
(
    input  logic [XLEN-1:0] src,
    input  logic            src_is_imm,
    input  logic [SZ_W-1:0] imm_width,
    output logic [XLEN-1:0] src_eff
);
    logic [XLEN-1:0] ext_by_width [N_SIZES];

    for (genvar g = 0; g < N_SIZES; g++) begin : g_ext
        localparam int W = 8 << g;
        if (W == XLEN) begin : g_full
            assign ext_by_width[g] = src;
        end else begin : g_part
            assign ext_by_width[g] = {{(XLEN-W){src[W-1]}}, src[W-1:0]};
        end
    end

    always_comb begin
        src_eff = src_is_imm ? ext_by_width[imm_width] : src;
    end
endmodule

// File: rtl/adc_sum_flags.sv
module adc_sum_flags
    import adc_pkg::*;
(
    input  logic [XLEN-1:0] dst,
    input  logic [XLEN-1:0] src_eff,
    input  logic [SZ_W-1:0] op_size,
    input  logic            carry_in,
    output logic [XLEN-1:0] sum,
    output flags_t          flags
);
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] a_m;
    logic [XLEN-1:0] b_m;
    logic [XLEN:0]   full;
    logic [XLEN-1:0] x3;
    int unsigned     top;

    always_comb begin
        mask = size_mask(op_size);
        a_m  = dst & mask;
        b_m  = src_eff & mask;
        full = {1'b0, a_m} + {1'b0, b_m} + {{XLEN{1'b0}}, carry_in};
        sum  = full[XLEN-1:0] & mask;
        top  = (8 << op_size) - 1;
        x3   = a_m ^ b_m ^ sum;

        flags.cf_f = full[top+1];
        flags.of_f = (a_m[top] == b_m[top]) && (sum[top] != a_m[top]);
        flags.sf_f = sum[top];
        flags.zf_f = (sum == '0);
        flags.af_f = x3[4];
        flags.pf_f = ~^sum[7:0];
    end
endmodule

// File: rtl/adc_flag_alu.sv
module adc_flag_alu
    import adc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [63:0] dst,
    input  logic [63:0] src,
    input  logic [1:0]  op_size,
    input  logic        carry_in,
    input  logic        src_is_imm,
    input  logic [1:0]  imm_width,
    output logic        out_valid,
    output logic [63:0] result,
    output logic        cf,
    output logic        of,
    output logic        sf,
    output logic        zf,
    output logic        af,
    output logic        pf
);
    typedef struct packed {
        logic            valid;
        logic [SZ_W-1:0] size;
        logic [XLEN-1:0] res;
        flags_t          fl;
    } state_t;

    logic [XLEN-1:0] src_eff;
    logic [XLEN-1:0] sum_c;
    flags_t          flags_c;
    state_t          st_d, st_q;

    adc_imm_extend u_ext (
        .src        (src),
        .src_is_imm (src_is_imm),
        .imm_width  (imm_width),
        .src_eff    (src_eff)
    );

    adc_sum_flags u_sum (
        .dst      (dst),
        .src_eff  (src_eff),
        .op_size  (op_size),
        .carry_in (carry_in),
        .sum      (sum_c),
        .flags    (flags_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.size = op_size;
            st_d.res  = sum_c;
            st_d.fl   = flags_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.res;
    assign cf        = st_q.fl.cf_f;
    assign of        = st_q.fl.of_f;
    assign sf        = st_q.fl.sf_f;
    assign zf        = st_q.fl.zf_f;
    assign af        = st_q.fl.af_f;
    assign pf        = st_q.fl.pf_f;

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((result & ~size_mask(st_q.size)) == '0)); // R1
    AST_SIGN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (sf == result[(8 << st_q.size) - 1])); // R5
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (zf == (result == '0))); // R6
    AST_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pf == ~^result[7:0])); // R8
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && !out_valid)); // R9
endmodule

// File: tb/tb_adc_flag_alu.sv
module tb_adc_flag_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] dst = '0;
    logic [63:0] src = '0;
    logic [1:0]  op_size = '0;
    logic        carry_in = 1'b0;
    logic        src_is_imm = 1'b0;
    logic [1:0]  imm_width = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        cf, of, sf, zf, af, pf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    adc_flag_alu dut (.*);

    typedef struct packed {
        logic [1:0]  sz;
        logic [63:0] d;
        logic [63:0] s;
        logic        ci;
        logic        imm;
        logic [1:0]  iw;
        logic [63:0] r;
        logic [5:0]  fl;   // {of, sf, zf, af, pf, cf}
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 64'hFF, 64'h01, 1'b0, 1'b0, 2'd0, 64'h0, 6'b001111},
        '{2'd0, 64'h7F, 64'h00, 1'b1, 1'b0, 2'd0, 64'h80, 6'b110100},
        '{2'd1, 64'hAAAA_0000_0000_8000, 64'h8000, 1'b0, 1'b0, 2'd0, 64'h0, 6'b101011},
        '{2'd2, 64'h10, 64'hFF, 1'b0, 1'b1, 2'd0, 64'h0F, 6'b000011},
        '{2'd3, 64'h5, 64'h8000_0000, 1'b0, 1'b1, 2'd2, 64'hFFFF_FFFF_8000_0005, 6'b010010},
        '{2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b0, 2'd0, 64'h0, 6'b001111},
        '{2'd1, 64'h1, 64'hFFFF, 1'b1, 1'b1, 2'd1, 64'h1, 6'b000101},
        '{2'd2, 64'h7FFF_FFFF, 64'h1, 1'b0, 1'b0, 2'd0, 64'h8000_0000, 6'b110110},
        '{2'd3, 64'h1, 64'h80, 1'b0, 1'b1, 2'd3, 64'h81, 6'b000010}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] sz, input logic [63:0] d, input logic [63:0] s,
                         input logic ci, input logic imm, input logic [1:0] iw);
        @(negedge clk);
        op_size = sz; dst = d; src = s; carry_in = ci; src_is_imm = imm; imm_width = iw;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [63:0] held;
        logic [31:0] a32, b32, sum32;
        logic [127:0] a128, b128, s128;
        logic c;

        // R10: reset state
        #12;
        check("R10 out_valid", {63'b0, out_valid}, 64'h0);
        check("R10 result", result, 64'h0);
        check("R10 flags", {58'b0, of, sf, zf, af, pf, cf}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1-R8 table walk
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].sz, VECS[i].d, VECS[i].s, VECS[i].ci, VECS[i].imm, VECS[i].iw);
            check("R9 out_valid", {63'b0, out_valid}, 64'h1);
            check("R1/R2 result", result, VECS[i].r);
            check("R3/R4/R5/R6/R7/R8 flags", {58'b0, of, sf, zf, af, pf, cf}, {58'b0, VECS[i].fl});
        end

        // R9: hold when idle, out_valid drops
        held = result;
        @(negedge clk);
        dst = 64'h1234; src = 64'h4321;
        @(negedge clk);
        check("R9 idle out_valid", {63'b0, out_valid}, 64'h0);
        check("R9 idle hold", result, held);

        // R11: 32-bit sum from four 8-bit steps
        a32 = 32'hF0FF_FF80; b32 = 32'h0F00_00A0;
        sum32 = a32 + b32;
        c = 1'b0;
        for (int k = 0; k < 4; k++) begin
            issue(2'd0, {56'b0, a32[8*k +: 8]}, {56'b0, b32[8*k +: 8]}, c, 1'b0, 2'd0);
            check("R11 byte chain", result, {56'b0, sum32[8*k +: 8]});
            c = cf;
        end
        check("R11 byte chain final carry", {63'b0, c}, {63'b0, ({1'b0, a32} + {1'b0, b32}) >> 32});

        // R11: 128-bit sum from two 64-bit steps
        a128 = {64'h1, 64'hFFFF_FFFF_FFFF_FFFF};
        b128 = {64'h0, 64'h1};
        s128 = a128 + b128;
        issue(2'd3, a128[63:0], b128[63:0], 1'b0, 1'b0, 2'd0);
        check("R11 low word", result, s128[63:0]);
        c = cf;
        check("R3 low carry", {63'b0, c}, 64'h1);
        issue(2'd3, a128[127:64], b128[127:64], c, 1'b0, 2'd0);
        check("R11 high word", result, s128[127:64]);

        // R10: reset clears after activity
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 reset clears result", result, 64'h0);
        check("R10 reset clears valid", {63'b0, out_valid}, 64'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule